// File: doc/BRIEF.md
# Single-Field Read-Modify-Write Engine

This block updates one bit field of one 32-bit word held in a small internal register array. A requester presents a packed 32-bit descriptor, which carries a word address, a field width and a bit offset, along with a data value. It then pulses `start`. The engine reads the addressed word and clears the bits of the field. It places the value, cut to the field width, at the field position and writes the word back. The other bits of the word keep their old values.

The word address is added to a base parameter. The low bits of the sum select the array entry, so `DEPTH` must be a power of two. A side read port shows any entry at any time, so that a requester or a bench can see the result. A field that runs past bit 31 is refused with a one-cycle error pulse. When an update completes, the engine gives a one-cycle `done` pulse.

Top module: `field_rmw_engine`

## Requirements
- R1: Descriptor layout: bits [31:16] are the word address, bits [15:8] the field width in bits, bits [7:0] the lowest bit position of the field.
- R2: The array entry updated is (word address + `BASE_ADDR`) modulo `DEPTH`. No other entry changes.
- R3: Bits offset to offset+width-1 of the entry take the new value. Every other bit keeps its old value.
- R4: Only the low `width` bits of `wr_value` are used. Higher value bits have no effect on the word.
- R5: A width of 0 leaves the word unchanged, and `done` still pulses.
- R6: Width 32 with offset 0 replaces the whole word with `wr_value`. Offset+width equal to 32 is accepted.
- R7: When offset+width exceeds 32, `err` is high for exactly the one cycle after the accepting edge. No entry is written and `done` does not pulse.
- R8: A start accepted on edge E0 reads on E1 and writes on E2. `done` is high for exactly the one cycle after E2. `busy` is high from E0 until `done` falls.
- R9: `start` while `busy` is high is ignored. The descriptor and value presented then have no effect.
- R10: After reset, `busy`, `done` and `err` are low and every array entry reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one field update; taken when not busy |
| desc | input | 32 | Packed field descriptor (address, width, offset) |
| wr_value | input | 32 | Value for the field, truncated to width |
| busy | output | 1 | Engine is processing a request |
| done | output | 1 | One-cycle pulse after the write-back |
| err | output | 1 | One-cycle pulse for a field out of the word |
| peek_idx | input | IDX_W | Array entry index for observation |
| peek_data | output | 32 | Current contents of entry `peek_idx` |

## Verification
The assertions rely on the requester holding `desc` and `wr_value` only at the accepting edge. The engine latches them there, so later changes to these inputs do not matter. The assertions also take reset to be applied at the start of a run. The bench drives all inputs at falling edges and pulses `start` for one cycle. The one exception is the busy test, which holds `start` high on purpose for an extra cycle with a different descriptor. Every entry is observed through `peek_idx` only between operations.

// File: rtl/field_rmw_engine.sv
module field_rmw_engine #(
  parameter int DEPTH     = 16,
  parameter int BASE_ADDR = 4,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      desc,
  input  logic [31:0]      wr_value,
  output logic             busy,
  output logic             done,
  output logic             err,
  input  logic [IDX_W-1:0] peek_idx,
  output logic [31:0]      peek_data
);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WRITE, S_DONE, S_ERR} state_t;

  state_t      state;
  logic [31:0] desc_q, val_q, old_q;
  logic [31:0] mem [DEPTH];

  logic [8:0]  span;
  logic        bad_range, accept;
  logic [15:0] tgt_addr;
  logic [IDX_W-1:0] idx;
  logic [7:0]  f_w, f_off;
  logic [31:0] low_ones, fmask, new_word;

  assign span      = {1'b0, desc[15:8]} + {1'b0, desc[7:0]};
  assign bad_range = span > 9'd32;
  assign accept    = start && (state == S_IDLE);

  assign f_w      = desc_q[15:8];
  assign f_off    = desc_q[7:0];
  assign tgt_addr = desc_q[31:16] + BASE_ADDR[15:0];
  assign idx      = tgt_addr[IDX_W-1:0];
  assign low_ones = (f_w >= 8'd32) ? 32'hFFFF_FFFF : ((32'd1 << f_w[5:0]) - 32'd1);
  assign fmask    = low_ones << f_off[4:0];
  assign new_word = (old_q & ~fmask) | ((val_q & low_ones) << f_off[4:0]);

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign err       = (state == S_ERR);
  assign peek_data = mem[peek_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      desc_q <= '0;
      val_q  <= '0;
      old_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          desc_q <= desc;
          val_q  <= wr_value;
          state  <= bad_range ? S_ERR : S_READ;
        end
        S_READ: begin
          old_q <= mem[idx];
          state <= S_WRITE;
        end
        S_WRITE: state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (state == S_WRITE) begin
      mem[idx] <= new_word;
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err && !busy);

  assert_bad_range_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && bad_range) |=> err);

  assert_start_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_exclusive_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));

  assert_keep_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((mem[idx] & ~fmask) == (old_q & ~fmask)));

endmodule

// File: tb/test_field_rmw_engine.sv
`timescale 1ns/1ps
module test_field_rmw_engine;
  localparam int DEPTH = 16;
  localparam int BASE  = 4;
  localparam int IW    = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] desc = '0, wr_value = '0;
  logic busy, done, err;
  logic [IW-1:0] peek_idx = '0;
  logic [31:0] peek_data;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  field_rmw_engine #(.DEPTH(DEPTH), .BASE_ADDR(BASE)) i_field_rmw_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .desc(desc), .wr_value(wr_value),
    .busy(busy), .done(done), .err(err), .peek_idx(peek_idx), .peek_data(peek_data));

  // desc, value, observed index, expected word
  localparam int NV = 7;
  localparam logic [31:0] TV_DESC [NV] = '{32'h0000_2000, 32'h0000_0808, 32'h0000_041C,
    32'h0000_0005, 32'h0000_011F, 32'h0003_1000, 32'h001C_0304};
  localparam logic [31:0] TV_VAL  [NV] = '{32'h1234_5678, 32'h0000_00AB, 32'h0000_0FF5,
    32'hFFFF_FFFF, 32'h0000_0001, 32'hCAFE_BEEF, 32'h0000_0007};
  localparam int          TV_IDX  [NV] = '{4, 4, 4, 4, 4, 7, 0};
  localparam logic [31:0] TV_EXP  [NV] = '{32'h1234_5678, 32'h1234_AB78, 32'h5234_AB78,
    32'h5234_AB78, 32'hD234_AB78, 32'h0000_BEEF, 32'h0000_0070};
  localparam string       TV_REQ  [NV] = '{"R6", "R3", "R4", "R5", "R3", "R2", "R1"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input int i, output logic [31:0] d);
    peek_idx = i[IW-1:0];
    #0.5;
    d = peek_data;
  endtask

  // lat: falling edges after the start edge until done/err (-1 if none)
  task automatic run_op(input logic [31:0] d, input logic [31:0] v,
                        output int lat, output logic saw_err, output int n_done);
    @(negedge clk); start = 1'b1; desc = d; wr_value = v;
    @(negedge clk); start = 1'b0; desc = '0; wr_value = '0;
    lat = -1; saw_err = 1'b0; n_done = 0;
    for (int k = 0; k < 8; k++) begin
      if (done) begin n_done++; if (lat < 0) lat = k; end
      if (err) begin saw_err = 1'b1; if (lat < 0) lat = k; end
      @(negedge clk);
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    int lat, nd;
    logic e;
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", {31'b0, busy}, 0);
    check("R10 done", {31'b0, done}, 0);
    check("R10 err", {31'b0, err}, 0);
    peek(9, w); check("R10 word", w, 0);

    for (int t = 0; t < NV; t++) begin
      run_op(TV_DESC[t], TV_VAL[t], lat, e, nd);
      peek(TV_IDX[t], w);
      check(TV_REQ[t], w, TV_EXP[t]);
      check("R8 latency", lat, 2);
      check("R8 done once", nd, 1);
    end
    peek(4, w); check("R2 other entry untouched", w, 32'hD234_AB78);

    // R7 field past bit 31: w=8, o=25
    run_op(32'h0000_0819, 32'hFFFF_FFFF, lat, e, nd);
    check("R7 err", {31'b0, e}, 1);
    check("R7 err latency", lat, 0);
    check("R7 no done", nd, 0);
    peek(4, w); check("R7 no write", w, 32'hD234_AB78);

    // R6 offset+width exactly 32 accepted: w=8, o=24
    run_op(32'h0000_0818, 32'h0000_0011, lat, e, nd);
    check("R6 no err", {31'b0, e}, 0);
    peek(4, w); check("R6 top byte", w, 32'h1134_AB78);

    // R9 start held while busy with another descriptor
    @(negedge clk); start = 1'b1; desc = 32'h0003_0810; wr_value = 32'h5A;
    @(negedge clk);
    check("R8 busy", {31'b0, busy}, 1);
    desc = 32'h0005_2000; wr_value = 32'hDEAD;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 8; k++) @(negedge clk);
    peek(7, w); check("R9 first applied", w, 32'h005A_BEEF);
    peek(9, w); check("R9 second ignored", w, 0);
    check("R8 idle after", {31'b0, busy}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule